// File: doc/BRIEF.md
# Two-Phase Prescaled Watchdog Timer

This block is a watchdog timer on a simple word-addressed register bus. Software sets an enable bit, a tick prescale and two phase lengths in one control word. When the enable bit is set, a power-of-two prescaler produces ticks and a sequencer counts them through two phases. The first phase is an early warning: when it ends, a level interrupt asks software to act. The second phase is the last chance: when it ends, the block drives a fixed-length system reset pulse and then disables itself.

Software keeps the timer alive by writing a fixed key word to the kick register. A kick starts the count again at the beginning of phase 1 and withdraws a pending warning. Clearing the enable bit stops the timer. Setting it again starts the full sequence from the beginning.

Top module: `wdt_twophase`

## Requirements
- R1: After reset the control word reads 0, and `irq_o` and `rst_o` are low.
- R2: Word 0 is the control register. Bit 31 is enable, bits 30:29 are prescale, bits 26:22 are the phase-1 field and bits 19:15 are the phase-2 field. All other bits read as zero. Word 1 is the kick register and reads 0. In word 2, bit 0 is the pending warning, and writing 1 to it clears the warning.
- R3: One tick lasts 2^(TICK_BASE_LOG2 + prescale) clock cycles.
- R4: Phase 1 lasts (phase-1 field + 1) ticks, counted from the clock edge that takes the enable write. `irq_o` rises after the last of those ticks.
- R5: Phase 2 follows at once and lasts (phase-2 field + 1) ticks. At its end, `rst_o` rises.
- R6: A write of KICK_CODE to word 1 while the block is enabled restarts phase 1 from that edge and drops `irq_o`.
- R7: Writing 0 to the enable bit stops the timer. No interrupt and no reset follow.
- R8: `rst_o` stays high for RST_PULSE_LEN (16) cycles. After that, the enable bit reads 0.
- R9: `irq_o` is a level. It stays high until the status bit is cleared by a write of 1 or the block is kicked, even after the reset pulse.
- R10: A write to word 1 with any value other than KICK_CODE is ignored and leaves the timing unchanged. A kick while the block is disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 2 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Pre-timeout warning, level |
| rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume that each bus write is a one-cycle strobe with stable address and data. They also assume that nothing but the bus and the reset input changes the block's state. The bench drives every write on a falling edge and drops the strobe on the next falling edge, so each write lands on exactly one rising edge. It reads outputs only on falling edges. The bench sets a small tick base so that each phase lasts a known, short number of cycles, and it places kicks, foreign writes and disable writes at cycle offsets that it counts itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W  = 2;
  localparam int PH_W  = 5;
  localparam int EN_BIT = 31;
  localparam int PS_LSB = 29;
  localparam int P1_LSB = 22;
  localparam int P2_LSB = 15;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_KICK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_PH1, ST_PH2, ST_FIRE} wdt_state_t;

  function automatic int unsigned tick_cycles(input int base, input int ps);
    return 32'd1 << (base + ps);
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic en, input logic [PS_W-1:0] ps,
                                            input logic [PH_W-1:0] p1,
                                            input logic [PH_W-1:0] p2);
    logic [31:0] w;
    w = '0;
    w[EN_BIT] = en;
    w[PS_LSB +: PS_W] = ps;
    w[P1_LSB +: PH_W] = p1;
    w[P2_LSB +: PH_W] = p2;
    return w;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [31:0] KICK_CODE = 32'h5A5A_C3C3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  input  logic            irq_i,
  input  logic            firing_i,
  input  logic            pulse_end_i,
  output logic            en_o,
  output logic [PS_W-1:0] ps_o,
  output logic [PH_W-1:0] p1_o,
  output logic [PH_W-1:0] p2_o,
  output logic            start_ev_o,
  output logic            stop_ev_o,
  output logic            kick_ev_o,
  output logic            irq_clr_o
);
  logic ctrl_wr;
  assign ctrl_wr    = bus_wr_i && bus_addr_i == A_CTRL;
  assign start_ev_o = ctrl_wr && bus_wdata_i[EN_BIT] && !en_o;
  assign stop_ev_o  = ctrl_wr && !bus_wdata_i[EN_BIT] && en_o && !firing_i;
  assign kick_ev_o  = bus_wr_i && bus_addr_i == A_KICK && bus_wdata_i == KICK_CODE
                      && en_o && !firing_i;
  assign irq_clr_o  = bus_wr_i && bus_addr_i == A_STAT && bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      ps_o <= '0;
      p1_o <= '0;
      p2_o <= '0;
    end else begin
      if (pulse_end_i) en_o <= 1'b0;
      else if (ctrl_wr && !firing_i) en_o <= bus_wdata_i[EN_BIT];
      if (ctrl_wr) begin
        ps_o <= bus_wdata_i[PS_LSB +: PS_W];
        p1_o <= bus_wdata_i[P1_LSB +: PH_W];
        p2_o <= bus_wdata_i[P2_LSB +: PH_W];
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = pack_ctrl(en_o, ps_o, p1_o, p2_o);
      A_STAT:  bus_rdata_o = {31'd0, irq_i};
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int TICK_BASE_LOG2 = 25,
  localparam int CW = TICK_BASE_LOG2 + (1 << PS_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = CW'(tick_cycles(TICK_BASE_LOG2, int'(ps_i)) - 1);
  assign tick_o = run_i && !restart_i && cnt_q == last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || restart_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  p_tick_needs_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(run_i) || $past(restart_i));
endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
  import wdt_pkg::*;
#(
  parameter int RST_PULSE_LEN = 16,
  localparam int PCW = $clog2(RST_PULSE_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            kick_i,
  input  logic            irq_clr_i,
  input  logic [PH_W-1:0] p1_i,
  input  logic [PH_W-1:0] p2_i,
  output logic            run_o,
  output logic            firing_o,
  output logic            pulse_end_o,
  output logic            phase1_done_o,
  output logic            phase2_done_o,
  output logic            irq_o,
  output logic            rst_o
);
  wdt_state_t    st_q;
  logic [PH_W-1:0] tcnt_q;
  logic [PCW-1:0]  pcnt_q;
  logic            phase_end;

  assign run_o         = st_q == ST_PH1 || st_q == ST_PH2;
  assign firing_o      = st_q == ST_FIRE;
  assign rst_o         = firing_o;
  assign phase_end     = tick_i && tcnt_q == (st_q == ST_PH1 ? p1_i : p2_i);
  assign phase1_done_o = phase_end && st_q == ST_PH1 && !kick_i && !stop_i;
  assign phase2_done_o = phase_end && st_q == ST_PH2 && !kick_i && !stop_i;
  assign pulse_end_o   = firing_o && pcnt_q == PCW'(RST_PULSE_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin st_q <= ST_PH1; tcnt_q <= '0; end
        ST_PH1, ST_PH2: begin
          if (stop_i) st_q <= ST_IDLE;
          else if (kick_i) begin st_q <= ST_PH1; tcnt_q <= '0; end
          else if (phase1_done_o) begin st_q <= ST_PH2; tcnt_q <= '0; end
          else if (phase2_done_o) begin st_q <= ST_FIRE; pcnt_q <= '0; end
          else if (tick_i) tcnt_q <= tcnt_q + 1'b1;
        end
        default: begin
          pcnt_q <= pcnt_q + 1'b1;
          if (pulse_end_o) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else if (kick_i) irq_o <= 1'b0;
    else if (phase1_done_o) irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end

  p_irq_from_phase1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(phase1_done_o));
  p_rst_from_phase2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(phase2_done_o));
  p_kick_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !irq_o && st_q == ST_PH1 && tcnt_q == '0);
  p_stop_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> st_q == ST_IDLE && !rst_o);
  p_pulse_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o && !pulse_end_o |=> rst_o);
  p_irq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i) || $past(kick_i));
endmodule

// File: rtl/wdt_twophase.sv
module wdt_twophase
  import wdt_pkg::*;
#(
  parameter int          TICK_BASE_LOG2 = 25,
  parameter int          RST_PULSE_LEN  = 16,
  parameter logic [31:0] KICK_CODE      = 32'h5A5A_C3C3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        rst_o
);
  logic            en, start_ev, stop_ev, kick_ev, irq_clr;
  logic [PS_W-1:0] ps;
  logic [PH_W-1:0] p1, p2;
  logic            run, firing, pulse_end, tick, phase1_done, phase2_done;

  wdt_regs #(.KICK_CODE(KICK_CODE)) u_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .irq_i(irq_o), .firing_i(firing), .pulse_end_i(pulse_end),
    .en_o(en), .ps_o(ps), .p1_o(p1), .p2_o(p2),
    .start_ev_o(start_ev), .stop_ev_o(stop_ev), .kick_ev_o(kick_ev), .irq_clr_o(irq_clr)
  );

  wdt_prescaler #(.TICK_BASE_LOG2(TICK_BASE_LOG2)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .restart_i(kick_ev || stop_ev), .ps_i(ps), .tick_o(tick)
  );

  wdt_phase_seq #(.RST_PULSE_LEN(RST_PULSE_LEN)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(start_ev), .stop_i(stop_ev),
    .kick_i(kick_ev), .irq_clr_i(irq_clr), .p1_i(p1), .p2_i(p2),
    .run_o(run), .firing_o(firing), .pulse_end_o(pulse_end),
    .phase1_done_o(phase1_done), .phase2_done_o(phase2_done),
    .irq_o(irq_o), .rst_o(rst_o)
  );

  p_pulse_end_disables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> !en);
  p_run_needs_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> en);
  p_foreign_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_KICK && bus_wdata_i != KICK_CODE) |-> !kick_ev);
endmodule

// File: tb/sim_wdt_twophase.sv
module sim_wdt_twophase;
  import wdt_pkg::*;
  localparam int          BASE = 2;
  localparam logic [31:0] KEY  = 32'h5A5A_C3C3;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, rst;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdt_twophase #(.TICK_BASE_LOG2(BASE), .RST_PULSE_LEN(16), .KICK_CODE(KEY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .rst_o(rst));

  function automatic int tick_len(input int ps);
    return 4 << ps;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_sig(input bit use_rst, inout int k);
    while (((use_rst ? rst : irq) == 0) && k < 4000) begin @(negedge clk); k++; end
  endtask

  task automatic ctrl_start(input int ps, input int p1, input int p2);
    bwrite(A_CTRL, (32'd1 << 31) | (32'(ps) << 29) | (32'(p1) << 22) | (32'(p2) << 15));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bread(A_CTRL, d);
    chk("R1 ctrl", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", rst, 0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    bwrite(A_CTRL, 32'h7FFF_FFFF);
    bread(A_CTRL, d);
    chk("R2 readback", d, 32'h67CF_8000);
    bread(A_KICK, d);
    chk("R2 kick reads 0", d, 0);
  endtask

  task automatic t_full(input int ps, input int p1, input int p2, input string tag);
    int k = 0, w = 0;
    logic [31:0] d;
    ctrl_start(ps, p1, p2);
    wait_sig(0, k);
    chk({tag, " R3 R4 irq time"}, k, (p1 + 1) * tick_len(ps));
    wait_sig(1, k);
    chk({tag, " R5 rst time"}, k, (p1 + p2 + 2) * tick_len(ps));
    while (rst && w < 100) begin @(negedge clk); w++; end
    chk({tag, " R8 pulse width"}, w, 16);
    bread(A_CTRL, d);
    chk({tag, " R8 enable cleared"}, d[31], 0);
    chk({tag, " R9 irq held"}, irq, 1);
    bwrite(A_STAT, 1);
    chk({tag, " R9 w1c clears"}, irq, 0);
  endtask

  task automatic t_kick;
    int k = 0;
    ctrl_start(0, 3, 3);
    repeat (9) @(negedge clk);
    bwrite(A_KICK, KEY);
    k = 0;
    wait_sig(0, k);
    chk("R6 irq time after kick", k, 16);
    bwrite(A_KICK, KEY);
    chk("R6 kick drops irq", irq, 0);
    bwrite(A_CTRL, 0);
  endtask

  task automatic t_foreign;
    int k = 0;
    ctrl_start(0, 1, 2);
    bwrite(A_KICK, KEY ^ 32'h1);
    k = 2;
    wait_sig(0, k);
    chk("R10 irq time unchanged", k, 8);
    bwrite(A_KICK, 32'h0);
    k += 2;
    wait_sig(1, k);
    chk("R10 rst time unchanged", k, 20);
    while (rst) @(negedge clk);
    bwrite(A_STAT, 1);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    ctrl_start(0, 0, 0);
    bwrite(A_CTRL, 0);
    repeat (100) @(negedge clk);
    chk("R7 no irq after stop", irq, 0);
    chk("R7 no rst after stop", rst, 0);
    bwrite(A_KICK, KEY);
    repeat (100) @(negedge clk);
    bread(A_CTRL, d);
    chk("R10 idle kick no enable", d[31], 0);
    chk("R10 idle kick no irq", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    bwrite(A_CTRL, 0);
    t_full(0, 2, 1, "a");
    t_full(1, 0, 0, "b");
    t_full(3, 0, 0, "c");
    t_kick();
    t_foreign();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule